// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block sits between a serial flash controller's configuration registers and its data shifter. It divides a fast reference clock down to the serial clock and drives the select lines for up to four flash devices. It also fixes where, in reference cycles, the select window opens and closes around each transfer. Software programs the divider, the clock polarity and phase, the device select field, the select mode and four delay counts, and then sets the enable bit. The shifter asks for a transfer of one to eight bytes with a start pulse. The block answers with sample and launch strobes on the right serial clock edges, and with a pulse at the end of each byte.

The settings are held in shadow registers. These load only while the enable bit is clear and the block is idle, so a transfer always runs on one consistent set of settings. Each transfer goes through these phases: an optional device-switch gap, the lead delay with select asserted, the clocked bytes, the tail delay, and the minimum deselect gap. The block reports busy from the accepted start until the deselect gap ends. Idle is the inverse of busy.

Top module: `spi_tm_top`

## Requirements
- R1: One serial clock half period is div+1 reference cycles, where div is the 4-bit divider field. A transfer of len+1 bytes makes exactly 16*(len+1) serial clock transitions and ends at the idle level.
- R2: Outside the select window (sel_n_o high), sclk_o rests at the polarity bit: 0 gives a low idle level and 1 gives a high idle level.
- R3: The edges of each clock period are numbered from 0, and even edges are the leading edges. With phase 0, sample_o pulses on leading edges and launch_o on trailing edges. With phase 1 the two are swapped. Each strobe pulses in the cycle in which sclk_o shows the new level, and each pulses 8 times per byte.
- R4: In direct mode (dec_mode 0), cs_n_o carries the 4-bit select field unchanged, active low, while sel_n_o is low, and 4'b1111 otherwise. For example, 4'b1110 selects device 0.
- R5: In decoder mode (dec_mode 1), cs_n_o carries the 4-bit field as a binary device code at all times, and sel_n_o low marks the select window.
- R6: After an accepted start (with no device switch), the select window opens in the next cycle. The first serial clock transition comes lead+div+3 cycles after the start cycle. That is lead+1 cycles of lead delay, followed by one half period.
- R7: The select window stays open for tail + 2*(div+1) + 3 cycles after the last serial clock transition, counting the cycle that shows that transition. The whole window is lead+1 + 16*(len+1)*(div+1) + tail+2*(div+1)+3 cycles long.
- R8: After the window closes, the block stays busy with select deasserted for gap + 2*(div+1) + 1 cycles.
- R9: If the select field differs from the field of the previous accepted transfer, sw+1 cycles with select deasserted come before the lead delay. The first transfer after reset never has this gap.
- R10: A start is accepted only while enabled and idle. The shadow settings load only while enable is clear and the block is idle, so changes made while enabled have no effect.
- R11: idle_o is 1 exactly when no transfer phase and no delay timer is active. busy_o is its inverse, and a start during the deselect gap is ignored.
- R12: byte_done_o pulses once per byte, len+1 times per transfer, in the cycle that shows the final (trailing) transition of the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| div_i | input | 4 | Clock divider field |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Sampling edge select |
| cs_i | input | 4 | Select field (pattern or code) |
| dec_mode_i | input | 1 | 1: decoder code, 0: direct active-low lines |
| dly_lead_i | input | 8 | Select-to-first-clock delay |
| dly_tail_i | input | 8 | Last-clock-to-deselect delay |
| dly_gap_i | input | 8 | Minimum deselect time |
| dly_sw_i | input | 8 | Device switch gap |
| start_i | input | 1 | Transfer request from the shifter |
| len_i | input | 3 | Byte count minus one |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 4 | Select lines or device code |
| sel_n_o | output | 1 | Select window, active low |
| sample_o | output | 1 | Sample strobe for the shifter |
| launch_o | output | 1 | Launch strobe for the shifter |
| byte_done_o | output | 1 | End of byte pulse |
| busy_o | output | 1 | Transfer or timer active |
| idle_o | output | 1 | No transfer and no timer active |

## Verification
The end of a byte falls in the same cycle as a serial clock transition. For the last byte it also falls in the same cycle as the move into the tail delay, so one cycle carries the byte-done pulse, the final trailing edge and the switch of the timer. Transfers of one to eight bytes at several dividers provoke this. It is judged by counting byte-done pulses, transitions and their spacing, and by measuring the window length against the tail formula. A start pulse driven while the deselect gap is still running tests the other coincidence. The bench then checks that busy ends on time and that no second window opens.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SWITCH = 3'd1,
    ST_LEAD   = 3'd2,
    ST_CLK    = 3'd3,
    ST_TAIL   = 3'd4,
    ST_GAP    = 3'd5
  } st_e;
endpackage

// File: rtl/spi_tm_cfg.sv
module spi_tm_cfg #(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CS_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [CS_W-1:0]  cs_i,
  input  logic             dec_i,
  input  logic [DLY_W-1:0] dly_i [4],
  output logic [DIV_W-1:0] div_o,
  output logic             cpol_o,
  output logic             cpha_o,
  output logic [CS_W-1:0]  cs_o,
  output logic             dec_o,
  output logic [DLY_W-1:0] dly_o [4]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= '0;
      cpol_o <= 1'b0;
      cpha_o <= 1'b0;
      cs_o   <= '1;
      dec_o  <= 1'b0;
    end else if (load_i) begin
      div_o  <= div_i;
      cpol_o <= cpol_i;
      cpha_o <= cpha_i;
      cs_o   <= cs_i;
      dec_o  <= dec_i;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_o[g] <= '0;
      else if (load_i) dly_o[g] <= dly_i[g];
    end
  end
endmodule

// File: rtl/spi_tm_clkgen.sv
module spi_tm_clkgen #(
  parameter int DIV_W = 4,
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             sclk_o,
  output logic             sample_o,
  output logic             launch_o,
  output logic             byte_done_o,
  output logic             last_o
);
  localparam int EW = LEN_W + 4;

  logic [DIV_W-1:0] hcnt_q;
  logic [EW-1:0]    ecnt_q;
  logic             tick;

  assign tick   = run_i && (hcnt_q == '0);
  assign last_o = tick && (ecnt_q == {len_i, 4'hF});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      ecnt_q <= '0;
      sclk_o <= 1'b0;
    end else if (!run_i) begin
      hcnt_q <= div_i;
      ecnt_q <= '0;
      sclk_o <= cpol_i;
    end else if (tick) begin
      hcnt_q <= div_i;
      ecnt_q <= ecnt_q + 1'b1;
      sclk_o <= ~sclk_o;
    end else begin
      hcnt_q <= hcnt_q - 1'b1;
    end
  end

  // even edge index = leading edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o    <= 1'b0;
      launch_o    <= 1'b0;
      byte_done_o <= 1'b0;
    end else begin
      sample_o    <= tick && (ecnt_q[0] == cpha_i);
      launch_o    <= tick && (ecnt_q[0] != cpha_i);
      byte_done_o <= tick && (ecnt_q[3:0] == 4'hF);
    end
  end
endmodule

// File: rtl/spi_tm_seq.sv
module spi_tm_seq
  import spi_tm_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             switch_i,
  input  logic             last_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] d_lead_i,
  input  logic [DLY_W-1:0] d_tail_i,
  input  logic [DLY_W-1:0] d_gap_i,
  input  logic [DLY_W-1:0] d_sw_i,
  output st_e              st_o,
  output logic             accept_o
);
  localparam int CNT_W = ((DLY_W > DIV_W + 1) ? DLY_W : DIV_W + 1) + 2;

  logic [CNT_W-1:0] cnt_q, p2;
  logic             cnt_zero;

  assign p2       = (CNT_W'(div_i) << 1) + CNT_W'(2);
  assign cnt_zero = (cnt_q == '0);
  assign accept_o = (st_o == ST_IDLE) && start_i && en_i;

  // a phase of N cycles loads N-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_o)
        ST_IDLE: if (accept_o) begin
          if (switch_i) begin
            st_o  <= ST_SWITCH;
            cnt_q <= CNT_W'(d_sw_i);
          end else begin
            st_o  <= ST_LEAD;
            cnt_q <= CNT_W'(d_lead_i);
          end
        end
        ST_SWITCH: if (cnt_zero) begin
          st_o  <= ST_LEAD;
          cnt_q <= CNT_W'(d_lead_i);
        end else cnt_q <= cnt_q - 1'b1;
        ST_LEAD: if (cnt_zero) st_o <= ST_CLK;
                 else          cnt_q <= cnt_q - 1'b1;
        ST_CLK: if (last_i) begin
          st_o  <= ST_TAIL;
          cnt_q <= CNT_W'(d_tail_i) + p2 + CNT_W'(2);
        end
        ST_TAIL: if (cnt_zero) begin
          st_o  <= ST_GAP;
          cnt_q <= CNT_W'(d_gap_i) + p2;
        end else cnt_q <= cnt_q - 1'b1;
        ST_GAP: if (cnt_zero) st_o <= ST_IDLE;
                else          cnt_q <= cnt_q - 1'b1;
        default: st_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_tm_top.sv
module spi_tm_top
  import spi_tm_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CS_W  = 4,
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [CS_W-1:0]  cs_i,
  input  logic             dec_mode_i,
  input  logic [DLY_W-1:0] dly_lead_i,
  input  logic [DLY_W-1:0] dly_tail_i,
  input  logic [DLY_W-1:0] dly_gap_i,
  input  logic [DLY_W-1:0] dly_sw_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             sclk_o,
  output logic [CS_W-1:0]  cs_n_o,
  output logic             sel_n_o,
  output logic             sample_o,
  output logic             launch_o,
  output logic             byte_done_o,
  output logic             busy_o,
  output logic             idle_o
);
  st_e              st;
  logic             accept, last, win, load;
  logic [DIV_W-1:0] div_q;
  logic             cpol_q, cpha_q, dec_q;
  logic [CS_W-1:0]  cs_q, last_cs_q;
  logic             have_last_q;
  logic [LEN_W-1:0] len_q;
  logic [DLY_W-1:0] dly_in [4];
  logic [DLY_W-1:0] dly_q  [4];

  assign dly_in[0] = dly_lead_i;
  assign dly_in[1] = dly_tail_i;
  assign dly_in[2] = dly_gap_i;
  assign dly_in[3] = dly_sw_i;

  assign idle_o = (st == ST_IDLE);
  assign busy_o = ~idle_o;
  assign load   = ~en_i & idle_o;
  assign win    = (st == ST_LEAD) || (st == ST_CLK) || (st == ST_TAIL);
  assign sel_n_o = ~win;

  spi_tm_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CS_W(CS_W)) u_cfg (
    .clk_i, .rst_ni, .load_i(load),
    .div_i, .cpol_i, .cpha_i, .cs_i, .dec_i(dec_mode_i), .dly_i(dly_in),
    .div_o(div_q), .cpol_o(cpol_q), .cpha_o(cpha_q), .cs_o(cs_q),
    .dec_o(dec_q), .dly_o(dly_q)
  );

  spi_tm_seq #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .en_i,
    .switch_i(have_last_q && (cs_q != last_cs_q)),
    .last_i(last), .div_i(div_q),
    .d_lead_i(dly_q[0]), .d_tail_i(dly_q[1]),
    .d_gap_i(dly_q[2]), .d_sw_i(dly_q[3]),
    .st_o(st), .accept_o(accept)
  );

  spi_tm_clkgen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_clk (
    .clk_i, .rst_ni, .run_i(st == ST_CLK),
    .div_i(div_q), .cpol_i(cpol_q), .cpha_i(cpha_q), .len_i(len_q),
    .sclk_o, .sample_o, .launch_o, .byte_done_o, .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_cs_q   <= '1;
      have_last_q <= 1'b0;
      len_q       <= '0;
    end else if (accept) begin
      last_cs_q   <= cs_q;
      have_last_q <= 1'b1;
      len_q       <= len_i;
    end
  end

  for (genvar g = 0; g < CS_W; g++) begin : g_cs
    assign cs_n_o[g] = (dec_q || win) ? cs_q[g] : 1'b1;
  end
endmodule

// File: rtl/spi_tm_chk.sv
module spi_tm_chk #(
  parameter int CS_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            sclk_o,
  input logic            sel_n_o,
  input logic [CS_W-1:0] cs_n_o,
  input logic            sample_o,
  input logic            launch_o,
  input logic            byte_done_o,
  input logic            idle_o,
  input logic            cpol_q,
  input logic            dec_q
);
  a_r2_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && sel_n_o) |-> (sclk_o == cpol_q));

  a_r3_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && launch_o));

  a_r12_done_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> (sclk_o != $past(sclk_o)) && (sclk_o == cpol_q));

  a_r4_direct_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_q && sel_n_o) |-> (cs_n_o == '1));

  a_r5_window_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_o && $past(!sel_n_o)) |-> $stable(cs_n_o));

  a_r11_idle_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (sel_n_o && !sample_o && !launch_o));
endmodule

bind spi_tm_top spi_tm_chk #(.CS_W(CS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sclk_o(sclk_o),
  .sel_n_o(sel_n_o), .cs_n_o(cs_n_o), .sample_o(sample_o),
  .launch_o(launch_o), .byte_done_o(byte_done_o), .idle_o(idle_o),
  .cpol_q(cpol_q), .dec_q(dec_q)
);

// File: tb/sim_spi_tm_top.sv
`timescale 1ns/1ps
module sim_spi_tm_top;
  logic       clk = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic [3:0] div_i = '0, cs_i = 4'hF;
  logic       cpol_i = 1'b0, cpha_i = 1'b0, dec_mode_i = 1'b0, start_i = 1'b0;
  logic [7:0] dly_lead_i = '0, dly_tail_i = '0, dly_gap_i = '0, dly_sw_i = '0;
  logic [2:0] len_i = '0;
  logic       sclk_o, sel_n_o, sample_o, launch_o, byte_done_o, busy_o, idle_o;
  logic [3:0] cs_n_o;

  int n_chk = 0, n_bad = 0;
  bit have_last = 0;
  logic [3:0] last_cs = 4'hF;

  always #4 clk = ~clk;

  spi_tm_top u0 (.clk_i(clk), .rst_ni, .en_i, .div_i, .cpol_i, .cpha_i, .cs_i,
    .dec_mode_i, .dly_lead_i, .dly_tail_i, .dly_gap_i, .dly_sw_i, .start_i,
    .len_i, .sclk_o, .cs_n_o, .sel_n_o, .sample_o, .launch_o, .byte_done_o,
    .busy_o, .idle_o);

  // div,cpol,cpha,cs,dec,lead,tail,gap,sw,len
  localparam logic [45:0] VEC [8] = '{
    {4'd0,  1'b0, 1'b0, 4'hE, 1'b0, 8'd0,   8'd0,   8'd0,   8'd0,   3'd0},
    {4'd1,  1'b1, 1'b0, 4'hE, 1'b0, 8'd3,   8'd2,   8'd1,   8'd5,   3'd1},
    {4'd2,  1'b0, 1'b1, 4'hD, 1'b0, 8'd1,   8'd0,   8'd4,   8'd3,   3'd0},
    {4'd0,  1'b1, 1'b1, 4'hB, 1'b0, 8'd7,   8'd5,   8'd0,   8'd0,   3'd2},
    {4'd3,  1'b0, 1'b0, 4'h2, 1'b1, 8'd2,   8'd1,   8'd2,   8'd2,   3'd0},
    {4'd15, 1'b1, 1'b1, 4'h2, 1'b1, 8'd0,   8'd9,   8'd3,   8'd1,   3'd0},
    {4'd0,  1'b0, 1'b1, 4'h7, 1'b0, 8'd255, 8'd255, 8'd255, 8'd255, 3'd7},
    {4'd5,  1'b1, 1'b0, 4'hE, 1'b0, 8'd4,   8'd3,   8'd6,   8'd9,   3'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [45:0] v);
    int dv, h, n, s, lead, tail, gap, sw;
    int j, busy, win, first_sel, first_tog, last_tog, tog, half_bad;
    int good_s, bad_s, la, bd, cs_in_bad, cs_out_bad, sclk_out_bad;
    logic cp, ph, dec, prev;
    logic [3:0] cs;
    bit need_sw;
    dv = int'(v[45:42]); cp = v[41]; ph = v[40]; cs = v[39:36]; dec = v[35];
    lead = int'(v[34:27]); tail = int'(v[26:19]); gap = int'(v[18:11]);
    sw = int'(v[10:3]); n = int'(v[2:0]) + 1; h = dv + 1;
    need_sw = have_last && (cs != last_cs);
    s = need_sw ? sw + 1 : 0;
    @(negedge clk);
    en_i = 1'b0; div_i = v[45:42]; cpol_i = cp; cpha_i = ph; cs_i = cs;
    dec_mode_i = dec; dly_lead_i = v[34:27]; dly_tail_i = v[26:19];
    dly_gap_i = v[18:11]; dly_sw_i = v[10:3]; len_i = v[2:0];
    repeat (2) @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);
    check(sclk_o == cp, "R2 idle level before start", int'(sclk_o), int'(cp));
    start_i = 1'b1;
    j = 0; busy = 0; win = 0; first_sel = 0; first_tog = 0; last_tog = 0;
    tog = 0; half_bad = 0; good_s = 0; bad_s = 0; la = 0; bd = 0;
    cs_in_bad = 0; cs_out_bad = 0; sclk_out_bad = 0; prev = cp;
    while (j < 20000) begin
      @(negedge clk);
      start_i = 1'b0;
      j++;
      if (idle_o) break;
      busy++;
      if (!sel_n_o) begin
        win++;
        if (first_sel == 0) first_sel = j;
        if (cs_n_o != cs) cs_in_bad++;
      end else begin
        if (sclk_o != cp) sclk_out_bad++;
        if (cs_n_o != (dec ? cs : 4'hF)) cs_out_bad++;
      end
      if (sclk_o != prev) begin
        tog++;
        if (first_tog == 0) first_tog = j;
        else if (j - last_tog != h) half_bad++;
        last_tog = j;
      end
      prev = sclk_o;
      if (sample_o) begin
        if (sclk_o == (ph ? cp : ~cp)) good_s++; else bad_s++;
      end
      if (launch_o) la++;
      if (byte_done_o) bd++;
    end
    check(first_sel == s + 1, "R9 window open cycle", first_sel, s + 1);
    check(first_tog == s + lead + h + 2, "R6 first clock transition", first_tog, s + lead + h + 2);
    check(tog == 16 * n, "R1 transition count", tog, 16 * n);
    check(half_bad == 0, "R1 half period spacing", half_bad, 0);
    check(win == lead + 1 + 16 * n * h + tail + 2 * h + 3, "R7 window length",
          win, lead + 1 + 16 * n * h + tail + 2 * h + 3);
    check(busy == s + lead + 1 + 16 * n * h + tail + 2 * h + 3 + gap + 2 * h + 1,
          "R8 busy length", busy, s + lead + 1 + 16 * n * h + tail + 2 * h + 3 + gap + 2 * h + 1);
    check(good_s == 8 * n, "R3 sample edges", good_s, 8 * n);
    check(bad_s == 0, "R3 sample on wrong edge", bad_s, 0);
    check(la == 8 * n, "R3 launch strobes", la, 8 * n);
    check(bd == n, "R12 byte done count", bd, n);
    check(cs_in_bad == 0, dec ? "R5 code in window" : "R4 pattern in window", cs_in_bad, 0);
    check(cs_out_bad == 0, dec ? "R5 code outside window" : "R4 deselect value", cs_out_bad, 0);
    check(sclk_out_bad == 0, "R2 idle level outside window", sclk_out_bad, 0);
    check(idle_o && !busy_o && sel_n_o, "R11 idle at end", int'(idle_o), 1);
    have_last = 1; last_cs = cs;
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check(idle_o == 1'b1 && busy_o == 1'b0, "R11 reset idle", int'(idle_o), 1);
    check(sel_n_o == 1'b1 && cs_n_o == 4'hF, "R4 reset deselect", int'(cs_n_o), 15);
    check(sclk_o == 1'b0, "R2 reset clock level", int'(sclk_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 8; k++) run_vec(VEC[k]);

    // R10: changes while enabled are ignored (last vector: cpol 1, cs E, direct)
    @(negedge clk);
    cpol_i = 1'b0; cs_i = 4'h7; dec_mode_i = 1'b1;
    repeat (3) @(negedge clk);
    check(sclk_o == 1'b1, "R10 polarity held while enabled", int'(sclk_o), 1);
    check(cs_n_o == 4'hF, "R10 mode held while enabled", int'(cs_n_o), 15);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    while (sel_n_o && cnt < 100) begin @(negedge clk); cnt++; end
    check(cs_n_o == 4'hE, "R10 select field held while enabled", int'(cs_n_o), 14);
    // R11: start during the deselect gap is ignored
    cnt = 0;
    while (!sel_n_o && cnt < 5000) begin @(negedge clk); cnt++; end
    check(busy_o == 1'b1, "R11 busy in deselect gap", int'(busy_o), 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    while (!idle_o && cnt < 5000) begin @(negedge clk); cnt++; end
    cnt = 0;
    repeat (8) begin @(negedge clk); if (!idle_o || !sel_n_o) cnt++; end
    check(cnt == 0, "R11 gap start ignored", cnt, 0);

    // R10: start ignored while disabled; shadow loads when disabled
    en_i = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk_o == 1'b0, "R10 polarity loads when disabled", int'(sclk_o), 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    repeat (10) begin @(negedge clk); if (!idle_o || !sel_n_o) cnt++; end
    check(cnt == 0, "R10 start ignored while disabled", cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule